// File: doc/BRIEF.md
# Long-latency result scoreboard

This block keeps track of which architectural registers are still waiting for a load or a multiply result in an in-order, single-issue pipeline. When such an operation leaves the register-read stage, its destination register is marked busy. Results come back through independent return ports, in any order, and each return frees its register. ALU results are never tracked, because they reach the read stage through forwarding.

The read stage presents the indices of the instruction it holds: its valid sources, its destination and its operation kind. The block raises a stall whenever that instruction reads a busy register or would overwrite one. Instructions that touch no busy register keep flowing, even while a cache-missing load is still outstanding. A return on the same cycle already counts as freed, so a stall ends on the cycle its result arrives. A flush removes only the entries that were marked as cancellable when they issued. Entries that had already committed stay busy.

Top module: `ldmul_scoreboard`

## Requirements
- R1: When the read stage holds a valid instruction of kind load (rd_kind=1) or multiply (rd_kind=2) with a valid destination, and stall_o and flush are both low, bit rd_dst of pend_o is 1 from the next cycle on.
- R2: An instruction of kind ALU (rd_kind=0) or no-op (rd_kind=3) never sets a pend_o bit.
- R3: stall_o is 1 exactly when rd_vld is 1 and a register named by a valid source (field k at bits [4k+3:4k] of rd_src_idx, enabled by rd_src_vld[k]) or by the valid destination is busy. A register is busy when its pend_o bit is 1 and no return port frees it in the current cycle.
- R4: A read-stage instruction whose registers are all free does not stall while other registers are busy.
- R5: A return (clr_vld[p]=1, index at bits [4p+3:4p] of clr_idx) drops a stall on that register in the same cycle, and the pend_o bit reads 0 from the next cycle on.
- R6: Return port 0 (loads) and return port 1 (multiplies) act independently. Both may fire in one cycle, and they may free registers in any order relative to issue.
- R7: If a register is set and freed in the same cycle, the set wins and the bit stays 1.
- R8: An instruction whose valid destination is busy stalls and marks nothing, which prevents a write-after-write race.
- R9: A flush clears the pend_o bits of entries issued with rd_cancel=1 and keeps those issued with rd_cancel=0. No new entry is set during a flush cycle.
- R10: After synchronous reset, pend_o is 0 and stall_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_vld | input | 1 | Read stage holds an instruction |
| rd_kind | input | 2 | 0 ALU, 1 load, 2 multiply, 3 no-op |
| rd_dst | input | 4 | Destination register index |
| rd_dst_vld | input | 1 | Destination index is used |
| rd_cancel | input | 1 | Entry may be removed by a flush |
| rd_src_idx | input | 8 | Packed source indices, 4 bits each |
| rd_src_vld | input | 2 | Per-source enable |
| clr_vld | input | 2 | Return strobes: port 0 load, port 1 multiply |
| clr_idx | input | 8 | Packed return indices, 4 bits each |
| flush | input | 1 | Remove cancellable entries |
| stall_o | output | 1 | Hold the read stage |
| pend_o | output | 16 | Busy register vector |

## Verification
The hardest cases to reach are the ones where two events meet on the same register in one cycle. One is a return that arrives while a new load or multiply to that register waits in the read stage: it must end the stall and let the new set win over the clear. The other is a flush that hits a mixture of cancellable and committed entries while the read stage also tries to issue. The directed tasks build these cases up. They first issue entries with chosen cancel flags and leave them busy, then line up the return, the issue and the flush on one cycle, and read pend_o on the following cycle.

// File: rtl/sb_pkg.sv
package sb_pkg;

  typedef enum logic [1:0] {
    OP_ALU  = 2'd0,
    OP_LOAD = 2'd1,
    OP_MUL  = 2'd2,
    OP_NONE = 2'd3
  } op_kind_e;

  // Only long-latency producers are tracked.
  function automatic logic is_tracked(op_kind_e k);
    return (k == OP_LOAD) || (k == OP_MUL);
  endfunction

endpackage

// File: rtl/sb_clear_merge.sv
module sb_clear_merge #(
  parameter int NREG = 16,
  parameter int NCLR = 2,
  parameter int IDXW = $clog2(NREG)
) (
  input  logic [NCLR-1:0]      clr_vld,
  input  logic [NCLR*IDXW-1:0] clr_idx,
  output logic [NREG-1:0]      clr_mask
);

  logic [NCLR-1:0][NREG-1:0] dec;

  // One decoder for each return port.
  for (genvar p = 0; p < NCLR; p++) begin : g_port
    assign dec[p] = clr_vld[p] ? (NREG'(1) << clr_idx[p*IDXW +: IDXW]) : '0;
  end

  always_comb begin
    clr_mask = '0;
    for (int p = 0; p < NCLR; p++) clr_mask = clr_mask | dec[p];
  end

endmodule

// File: rtl/sb_pend_store.sv
module sb_pend_store #(
  parameter int NREG = 16,
  parameter int IDXW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            set_en,
  input  logic [IDXW-1:0] set_idx,
  input  logic            set_canc,
  input  logic [NREG-1:0] clr_mask,
  input  logic            flush,
  output logic [NREG-1:0] pend_q
);

  logic [NREG-1:0] canc_q;
  logic [NREG-1:0] set_mask;
  logic [NREG-1:0] kill_mask;
  logic [NREG-1:0] pend_d;
  logic [NREG-1:0] canc_d;

  assign set_mask  = set_en ? (NREG'(1) << set_idx) : '0;
  assign kill_mask = flush ? canc_q : '0;
  // A new set overrides a clear of the same register.
  assign pend_d    = (pend_q & ~clr_mask & ~kill_mask) | set_mask;
  assign canc_d    = (canc_q & ~set_mask & pend_d) | (set_canc ? set_mask : '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      canc_q <= '0;
    end else begin
      pend_q <= pend_d;
      canc_q <= canc_d;
    end
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    set_en |=> pend_q[$past(set_idx)]); // R7

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
    (clr_mask != '0 && !set_en) |=> (($past(clr_mask) & pend_q) == '0)); // R5

  AST_COMMITTED_SURVIVE: assert property (@(posedge clk) disable iff (rst)
    flush |=> (($past(pend_q & ~canc_q & ~clr_mask) & ~pend_q) == '0)); // R9

  AST_FLUSH_NO_SET: assert property (@(posedge clk) disable iff (rst)
    flush |-> !set_en); // R9

endmodule

// File: rtl/sb_hazard_chk.sv
module sb_hazard_chk #(
  parameter int NREG = 16,
  parameter int NSRC = 2,
  parameter int IDXW = $clog2(NREG)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NREG-1:0]      pend_q,
  input  logic [NREG-1:0]      clr_mask,
  input  logic                 rd_vld,
  input  logic [NSRC*IDXW-1:0] rd_src_idx,
  input  logic [NSRC-1:0]      rd_src_vld,
  input  logic [IDXW-1:0]      rd_dst,
  input  logic                 rd_dst_vld,
  output logic                 stall
);

  logic [NREG-1:0] busy;
  logic [NSRC-1:0] src_hit;
  logic            dst_hit;

  // A result returning this cycle no longer blocks.
  assign busy = pend_q & ~clr_mask;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    assign src_hit[s] = rd_src_vld[s] & busy[rd_src_idx[s*IDXW +: IDXW]];
  end

  assign dst_hit = rd_dst_vld & busy[rd_dst];
  assign stall   = rd_vld & ((|src_hit) | dst_hit);

  AST_STALL_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    stall |-> (pend_q != '0)); // R3

  AST_IDLE_NO_STALL: assert property (@(posedge clk) disable iff (rst)
    !rd_vld |-> !stall); // R4

endmodule

// File: rtl/ldmul_scoreboard.sv
module ldmul_scoreboard #(
  parameter int NREG = 16,
  parameter int NSRC = 2,
  parameter int NCLR = 2,
  localparam int IDXW = $clog2(NREG)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rd_vld,
  input  logic [1:0]           rd_kind,
  input  logic [IDXW-1:0]      rd_dst,
  input  logic                 rd_dst_vld,
  input  logic                 rd_cancel,
  input  logic [NSRC*IDXW-1:0] rd_src_idx,
  input  logic [NSRC-1:0]      rd_src_vld,
  input  logic [NCLR-1:0]      clr_vld,
  input  logic [NCLR*IDXW-1:0] clr_idx,
  input  logic                 flush,
  output logic                 stall_o,
  output logic [NREG-1:0]      pend_o
);
  import sb_pkg::*;

  logic [NREG-1:0] clr_mask;
  logic [NREG-1:0] pend_q;
  logic            stall;
  logic            set_en;
  op_kind_e        kind;

  assign kind = op_kind_e'(rd_kind);

  sb_clear_merge #(.NREG(NREG), .NCLR(NCLR), .IDXW(IDXW)) u_merge (
    .clr_vld (clr_vld),
    .clr_idx (clr_idx),
    .clr_mask(clr_mask)
  );

  sb_hazard_chk #(.NREG(NREG), .NSRC(NSRC), .IDXW(IDXW)) u_haz (
    .clk       (clk),
    .rst       (rst),
    .pend_q    (pend_q),
    .clr_mask  (clr_mask),
    .rd_vld    (rd_vld),
    .rd_src_idx(rd_src_idx),
    .rd_src_vld(rd_src_vld),
    .rd_dst    (rd_dst),
    .rd_dst_vld(rd_dst_vld),
    .stall     (stall)
  );

  // Issue of a tracked producer: not held back and not being flushed.
  assign set_en = rd_vld & rd_dst_vld & is_tracked(kind) & ~stall & ~flush;

  sb_pend_store #(.NREG(NREG), .IDXW(IDXW)) u_store (
    .clk     (clk),
    .rst     (rst),
    .set_en  (set_en),
    .set_idx (rd_dst),
    .set_canc(rd_cancel),
    .clr_mask(clr_mask),
    .flush   (flush),
    .pend_q  (pend_q)
  );

  assign stall_o = stall;
  assign pend_o  = pend_q;

  AST_LONG_MARKED: assert property (@(posedge clk) disable iff (rst)
    (rd_vld && rd_dst_vld && (kind == OP_LOAD || kind == OP_MUL) && !stall_o && !flush)
    |=> pend_o[$past(rd_dst)]); // R1

  AST_ALU_UNMARKED: assert property (@(posedge clk) disable iff (rst)
    (rd_vld && rd_dst_vld && (kind == OP_ALU || kind == OP_NONE) && !pend_o[rd_dst])
    |=> !pend_o[$past(rd_dst)]); // R2

  AST_WAW_GUARD: assert property (@(posedge clk) disable iff (rst)
    set_en |-> !(pend_o[rd_dst] && !clr_mask[rd_dst])); // R8

endmodule

// File: tb/ldmul_scoreboard_tb.sv
module ldmul_scoreboard_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rd_vld = 1'b0;
  logic [1:0]  rd_kind = 2'd3;
  logic [3:0]  rd_dst = 4'd0;
  logic        rd_dst_vld = 1'b0;
  logic        rd_cancel = 1'b0;
  logic [7:0]  rd_src_idx = 8'd0;
  logic [1:0]  rd_src_vld = 2'b00;
  logic [1:0]  clr_vld = 2'b00;
  logic [7:0]  clr_idx = 8'd0;
  logic        flush = 1'b0;
  logic        stall_o;
  logic [15:0] pend_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ldmul_scoreboard dut_i (
    .clk(clk), .rst(rst), .rd_vld(rd_vld), .rd_kind(rd_kind), .rd_dst(rd_dst),
    .rd_dst_vld(rd_dst_vld), .rd_cancel(rd_cancel), .rd_src_idx(rd_src_idx),
    .rd_src_vld(rd_src_vld), .clr_vld(clr_vld), .clr_idx(clr_idx), .flush(flush),
    .stall_o(stall_o), .pend_o(pend_o)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    rd_vld = 0; rd_kind = 2'd3; rd_dst = 0; rd_dst_vld = 0; rd_cancel = 0;
    rd_src_idx = 0; rd_src_vld = 0; clr_vld = 0; clr_idx = 0; flush = 0;
  endtask

  task automatic rd(input logic [1:0] k, input logic [3:0] d, input logic dv,
                    input logic c, input logic [3:0] s0, input logic [3:0] s1,
                    input logic [1:0] sv);
    rd_vld = 1; rd_kind = k; rd_dst = d; rd_dst_vld = dv; rd_cancel = c;
    rd_src_idx = {s1, s0}; rd_src_vld = sv;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk); idle(); #1;
  endtask

  task automatic t_reset();
    chk("R10 pend", pend_o, 16'h0);
    chk("R10 stall", {15'd0, stall_o}, 16'h0);
  endtask

  task automatic t_mark();
    rd(2'd1, 4'd3, 1, 0, 4'd0, 4'd0, 2'b00); #1;
    chk("R1 no stall on issue", {15'd0, stall_o}, 16'h0);
    step(); chk("R1 load marked", pend_o, 16'h0008);
    rd(2'd2, 4'd5, 1, 0, 4'd0, 4'd0, 2'b00); step();
    chk("R1 mul marked", pend_o, 16'h0028);
    rd(2'd0, 4'd7, 1, 0, 4'd0, 4'd0, 2'b00); step();
    chk("R2 alu unmarked", pend_o, 16'h0028);
    rd(2'd3, 4'd9, 1, 0, 4'd0, 4'd0, 2'b00); step();
    chk("R2 noop unmarked", pend_o, 16'h0028);
  endtask

  task automatic t_depend();
    rd(2'd0, 4'd8, 1, 0, 4'd1, 4'd2, 2'b11); #1;
    chk("R4 independent flows", {15'd0, stall_o}, 16'h0);
    rd(2'd0, 4'd8, 1, 0, 4'd1, 4'd3, 2'b11); #1;
    chk("R3 source busy", {15'd0, stall_o}, 16'h1);
    rd(2'd0, 4'd8, 1, 0, 4'd1, 4'd3, 2'b01); #1;
    chk("R3 disabled source ignored", {15'd0, stall_o}, 16'h0);
    rd(2'd1, 4'd5, 1, 0, 4'd0, 4'd0, 2'b00); #1;
    chk("R8 waw stall", {15'd0, stall_o}, 16'h1);
    rd(2'd1, 4'd5, 1, 1, 4'd0, 4'd0, 2'b00); step();
    chk("R8 nothing set", pend_o, 16'h0028);
  endtask

  task automatic t_return();
    rd(2'd0, 4'd8, 1, 0, 4'd5, 4'd0, 2'b01);
    clr_vld = 2'b10; clr_idx = {4'd5, 4'd0}; #1;
    chk("R5 stall drops same cycle", {15'd0, stall_o}, 16'h0);
    step(); chk("R6 younger mul freed first", pend_o, 16'h0008);
    rd(2'd1, 4'd10, 1, 0, 4'd0, 4'd0, 2'b00); step();
    rd(2'd2, 4'd11, 1, 0, 4'd0, 4'd0, 2'b00); step();
    chk("R1 two more", pend_o, 16'h0C08);
    clr_vld = 2'b11; clr_idx = {4'd11, 4'd10}; step();
    chk("R6 both ports", pend_o, 16'h0008);
    clr_vld = 2'b01; clr_idx = {4'd0, 4'd3}; step();
    chk("R5 load freed", pend_o, 16'h0000);
  endtask

  task automatic t_setclr();
    rd(2'd1, 4'd4, 1, 0, 4'd0, 4'd0, 2'b00); step();
    rd(2'd2, 4'd4, 1, 0, 4'd0, 4'd0, 2'b00);
    clr_vld = 2'b01; clr_idx = {4'd0, 4'd4}; #1;
    chk("R7 no stall with return", {15'd0, stall_o}, 16'h0);
    step(); chk("R7 set wins", pend_o, 16'h0010);
    clr_vld = 2'b10; clr_idx = {4'd4, 4'd0}; step();
    chk("R5 cleared", pend_o, 16'h0000);
  endtask

  task automatic t_flush();
    rd(2'd1, 4'd6, 1, 1, 4'd0, 4'd0, 2'b00); step();
    rd(2'd2, 4'd12, 1, 0, 4'd0, 4'd0, 2'b00); step();
    rd(2'd1, 4'd2, 1, 1, 4'd0, 4'd0, 2'b00); step();
    chk("R1 mixed entries", pend_o, 16'h1044);
    rd(2'd1, 4'd9, 1, 0, 4'd0, 4'd0, 2'b00); flush = 1; step();
    chk("R9 flush keeps committed", pend_o, 16'h1000);
    clr_vld = 2'b10; clr_idx = {4'd12, 4'd0}; step();
    chk("R9 committed freed by return", pend_o, 16'h0000);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0; #1;
    t_reset();
    t_mark();
    t_depend();
    t_return();
    t_setclr();
    t_flush();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule